// File: doc/BRIEF.md
# Variable-Latency Memory Fill Responder

This block stands in for the backing memory behind a cache refill port. It holds a word-organised memory and answers line-sized requests. A write request updates memory immediately. A read request takes a snapshot of the addressed words when it is accepted. It then waits in a small pending table under a countdown loaded from the latency value that came with that request.

Each cycle, every pending countdown above zero drops by one. Once at least one entry has reached zero and the requester raises its fill-accept input, the block returns one whole line: the request's address and all of its captured words. The entry is then freed. Among several ready entries the lowest table slot goes first. A short-latency read can therefore overtake an older read that is still counting down. When the table is full, the block drops its ready output so that no read is lost.

Top module: `fill_responder`

## Requirements
- R1: Reset (synchronous, `rst_n` low at a rising edge) empties the pending table and clears every memory word to zero. After reset `req_ready` is 1 and `rsp_valid`, `rsp_addr` and `rsp_data` are 0. A read issued before the reset never produces a fill.
- R2: A read is accepted at a rising edge where `req_valid`, `req_rd` and `req_ready` are all 1. With `fill_accept` held at 1 and no other entry ready, its fill appears on the outputs L+1 rising edges after the acceptance edge, where L is `req_lat`. A latency of 0 therefore responds at the next edge.
- R3: A request covers `req_size`/4 words (integer division), capped at LINE_WORDS. The words sit at consecutive word indices starting at `req_addr[9:2]`, wrapping modulo MEM_WORDS (256); address bits [1:0] are ignored. Fill word i sits at `rsp_data[32*i +: 32]`, and lanes at or beyond the word count return 0. `rsp_addr` returns `req_addr` exactly as it was given.
- R4: Read data is captured from memory at the acceptance edge. A later write to the same words does not alter a fill that is already pending.
- R5: A write (`req_valid` and `req_wr`) stores lanes 0 to count-1 of `req_wdata` at the acceptance edge. A read accepted at any later edge sees the new data, and words beyond the count are left unchanged. A write creates no pending entry, never produces a fill, and does not depend on `req_ready`.
- R6: A fill is issued at a rising edge only if `fill_accept` is 1 at that edge and at least one entry has a countdown of zero. Issuing it frees that entry, so each accepted read is returned exactly once.
- R7: New reads take the lowest-numbered free slot. Among ready entries, the lowest-numbered slot is returned first, whatever the order in which the requests arrived or their latencies.
- R8: In any cycle after an edge that issued no fill, `rsp_valid`, `rsp_addr` and `rsp_data` are all 0.
- R9: With all DEPTH (4) slots occupied, `req_ready` is 0 and a presented read is not accepted. `req_ready` returns to 1 in the cycle after an edge that frees a slot.
- R10: Countdowns keep decrementing while `fill_accept` is 0. An entry that reaches zero waits there until a fill is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_rd | input | 1 | Request is a line read |
| req_wr | input | 1 | Request is a line write |
| req_addr | input | ADDR_W (32) | Byte address of the first word |
| req_size | input | SIZE_W (5) | Request size in bytes |
| req_wdata | input | LINE_W (128) | Write line, word i in bits 32*i+31:32*i |
| req_lat | input | LAT_W (8) | Countdown value for this read |
| req_ready | output | 1 | A pending slot is free; reads are accepted only when high |
| fill_accept | input | 1 | Requester can take a fill this cycle |
| rsp_valid | output | 1 | Fill response present |
| rsp_addr | output | ADDR_W (32) | Address of the returned line, 0 when idle |
| rsp_data | output | LINE_W (128) | Returned line, 0 when idle |

## Verification
A read accepted at edge E with latency L shows its fill after edge E+L+1. The bench drives every input on the falling edge and counts falling edges until `rsp_valid` rises, so it expects exactly L+1 of them. A write becomes visible to a read accepted at any later edge. `req_ready` reflects the table state in the same cycle as that state, so after the edge that fills or frees a slot the bench checks it at the next falling edge. Order checks release a set of already-ready entries with one rise of `fill_accept` and expect one fill per cycle, in slot order, starting at the first falling edge after that rise.

// File: rtl/fr_pkg.sv
// Package: shared constants for the fill responder.
// Assumes a 32-bit memory word and byte addressing.
package fr_pkg;
    localparam int WORD_W         = 32;
    localparam int BYTES_PER_WORD = WORD_W / 8;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/fr_pick.sv
// Lowest-index picker: grants the lowest set bit of req.
// Assumes N >= 1; purely combinational.
module fr_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        grant = '0;
        any   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fr_word_mem.sv
// Word memory with a line-wide window: reads combinationally and writes at the
// clock edge, LINE_WORDS consecutive words from base_idx, wrapping modulo WORDS.
// Assumes WORDS is a power of two. Reads see contents from before a same-edge write.
module fr_word_mem
    import fr_pkg::*;
#(
    parameter int WORDS      = 256,
    parameter int LINE_WORDS = 4,
    localparam int AW        = $clog2(WORDS),
    localparam int LINE_W    = LINE_WORDS * WORD_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         base_idx,
    input  logic [LINE_WORDS-1:0] word_en,
    input  logic                  wr_en,
    input  logic [LINE_W-1:0]     wr_line,
    output logic [LINE_W-1:0]     rd_line
);
    word_t mem_q [WORDS];

    // Clear on reset; otherwise store the enabled lanes of a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < WORDS; k++) begin
                mem_q[k] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < LINE_WORDS; i++) begin
                if (word_en[i]) begin
                    mem_q[base_idx + AW'(i)] <= wr_line[i*WORD_W +: WORD_W];
                end
            end
        end
    end

    // One read lane per line word; disabled lanes read as zero.
    for (genvar g = 0; g < LINE_WORDS; g++) begin : g_lane
        assign rd_line[g*WORD_W +: WORD_W] = word_en[g] ? mem_q[base_idx + AW'(g)] : '0;
    end
endmodule

// File: rtl/fr_pending_table.sv
// Pending read table: DEPTH slots, each holding an address, a captured line
// and a countdown. Allocates the lowest free slot and retires the lowest ready
// slot (countdown zero) when fill_accept is high.
// Assumes alloc_en is only raised while has_room is high.
module fr_pending_table #(
    parameter int DEPTH  = 4,
    parameter int LAT_W  = 8,
    parameter int ADDR_W = 32,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [LAT_W-1:0]  alloc_lat,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [LINE_W-1:0] alloc_data,
    input  logic              fill_accept,
    output logic              has_room,
    output logic              fire,
    output logic [ADDR_W-1:0] fire_addr,
    output logic [LINE_W-1:0] fire_data,
    output logic [DEPTH-1:0]  pend_valid,
    output logic [DEPTH-1:0]  ret_grant
);
    logic [DEPTH-1:0]  valid_q;
    logic [LAT_W-1:0]  cnt_q  [DEPTH];
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [LINE_W-1:0] data_q [DEPTH];
    logic [DEPTH-1:0]  ready_vec;
    logic [DEPTH-1:0]  free_grant;
    logic              ready_any;

    // Flag slots that hold a read whose countdown has expired.
    always_comb begin
        for (int e = 0; e < DEPTH; e++) begin
            ready_vec[e] = valid_q[e] && (cnt_q[e] == '0);
        end
    end

    fr_pick #(.N(DEPTH)) u_free_pick (
        .req   (~valid_q),
        .grant (free_grant),
        .any   (has_room)
    );

    fr_pick #(.N(DEPTH)) u_ready_pick (
        .req   (ready_vec),
        .grant (ret_grant),
        .any   (ready_any)
    );

    assign fire       = fill_accept && ready_any;
    assign pend_valid = valid_q;

    // Select the retiring slot's payload with an AND-OR over the one-hot grant.
    always_comb begin
        fire_addr = '0;
        fire_data = '0;
        for (int e = 0; e < DEPTH; e++) begin
            fire_addr |= addr_q[e] & {ADDR_W{ret_grant[e]}};
            fire_data |= data_q[e] & {LINE_W{ret_grant[e]}};
        end
    end

    // Slot state: free on retire, fill on allocate, otherwise count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int e = 0; e < DEPTH; e++) begin
                cnt_q[e] <= '0;
            end
        end else begin
            for (int e = 0; e < DEPTH; e++) begin
                if (fire && ret_grant[e]) begin
                    valid_q[e] <= 1'b0;
                end else if (alloc_en && free_grant[e]) begin
                    valid_q[e] <= 1'b1;
                    cnt_q[e]   <= alloc_lat;
                end else if (valid_q[e] && cnt_q[e] != '0) begin
                    cnt_q[e] <= cnt_q[e] - LAT_W'(1);
                end
            end
        end
    end

    // Payload registers need no reset; they are only read while valid.
    always_ff @(posedge clk) begin
        for (int e = 0; e < DEPTH; e++) begin
            if (alloc_en && free_grant[e]) begin
                addr_q[e] <= alloc_addr;
                data_q[e] <= alloc_data;
            end
        end
    end
endmodule

// File: rtl/fill_responder.sv
// Variable-latency fill responder: backing memory for a cache refill port.
// Writes update memory at once; reads snapshot memory into a pending slot and
// are returned, lowest ready slot first, when fill_accept is high.
// Assumes byte addresses with word-aligned lines; bits [1:0] of req_addr are ignored.
module fill_responder
    import fr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int MEM_WORDS  = 256,
    parameter int DEPTH      = 4,
    parameter int LAT_W      = 8,
    localparam int SIZE_W    = $clog2(LINE_WORDS * BYTES_PER_WORD) + 1,
    localparam int LINE_W    = LINE_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [LINE_W-1:0] req_wdata,
    input  logic [LAT_W-1:0]  req_lat,
    output logic              req_ready,
    input  logic              fill_accept,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [LINE_W-1:0] rsp_data
);
    localparam int MEM_AW = $clog2(MEM_WORDS);

    logic [MEM_AW-1:0]     base_idx;
    logic [SIZE_W-1:0]     n_words;
    logic [LINE_WORDS-1:0] word_en;
    logic                  rd_go;
    logic                  wr_go;
    logic [LINE_W-1:0]     cap_line;
    logic                  fire;
    logic [ADDR_W-1:0]     fire_addr;
    logic [LINE_W-1:0]     fire_data;
    logic [DEPTH-1:0]      pend_valid;
    logic [DEPTH-1:0]      ret_grant;

    assign base_idx = req_addr[2 +: MEM_AW];
    assign n_words  = req_size >> 2;
    assign rd_go    = req_valid && req_rd && req_ready;
    assign wr_go    = req_valid && req_wr;

    // Lane i takes part when it lies below the request's word count.
    for (genvar g = 0; g < LINE_WORDS; g++) begin : g_en
        assign word_en[g] = SIZE_W'(g) < n_words;
    end

    fr_word_mem #(
        .WORDS      (MEM_WORDS),
        .LINE_WORDS (LINE_WORDS)
    ) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_idx (base_idx),
        .word_en  (word_en),
        .wr_en    (wr_go),
        .wr_line  (req_wdata),
        .rd_line  (cap_line)
    );

    fr_pending_table #(
        .DEPTH  (DEPTH),
        .LAT_W  (LAT_W),
        .ADDR_W (ADDR_W),
        .LINE_W (LINE_W)
    ) u_tab (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_en    (rd_go),
        .alloc_lat   (req_lat),
        .alloc_addr  (req_addr),
        .alloc_data  (cap_line),
        .fill_accept (fill_accept),
        .has_room    (req_ready),
        .fire        (fire),
        .fire_addr   (fire_addr),
        .fire_data   (fire_data),
        .pend_valid  (pend_valid),
        .ret_grant   (ret_grant)
    );

    // Response register: one fill per accepted edge, all zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !fire) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b1;
            rsp_addr  <= fire_addr;
            rsp_data  <= fire_data;
        end
    end
endmodule

// File: rtl/fr_checker.sv
// Property checker for fill_responder, attached by bind.
// Assumes synchronous active-low reset; all checks are disabled while it is low.
module fr_checker #(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 128,
    parameter int DEPTH  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              fill_accept,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic [LINE_W-1:0] rsp_data,
    input logic [DEPTH-1:0]  pend_valid,
    input logic [DEPTH-1:0]  ret_grant
);
    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pend_valid == '0));

    // R6
    fill_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(fill_accept));

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_addr == '0 && rsp_data == '0));

    // R7
    single_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ret_grant));

    // R9
    not_ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> (&pend_valid));
endmodule

bind fill_responder fr_checker #(
    .ADDR_W (ADDR_W),
    .LINE_W (LINE_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .fill_accept (fill_accept),
    .rsp_valid   (rsp_valid),
    .rsp_addr    (rsp_addr),
    .rsp_data    (rsp_data),
    .pend_valid  (pend_valid),
    .ret_grant   (ret_grant)
);

// File: tb/tb_fill_responder.sv
module tb_fill_responder;
    localparam int LINE_W = 128;
    localparam int MEMW   = 256;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_rd = 1'b0, req_wr = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [4:0]   req_size = '0;
    logic [127:0] req_wdata = '0;
    logic [7:0]   req_lat = '0;
    logic         req_ready;
    logic         fill_accept = 1'b0;
    logic         rsp_valid;
    logic [31:0]  rsp_addr;
    logic [127:0] rsp_data;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] shadow [MEMW];

    always #10 clk = ~clk;

    fill_responder dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rd(req_rd),
        .req_wr(req_wr), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .req_lat(req_lat), .req_ready(req_ready),
        .fill_accept(fill_accept), .rsp_valid(rsp_valid),
        .rsp_addr(rsp_addr), .rsp_data(rsp_data)
    );

    // addr, size (bytes), latency
    localparam logic [47:0] VEC [8] = '{
        {32'h0000_0010, 8'd16, 8'd0},
        {32'h0000_0040, 8'd4,  8'd1},
        {32'h0000_0104, 8'd8,  8'd3},
        {32'h0000_0200, 8'd12, 8'd7},
        {32'h0000_03F8, 8'd16, 8'd2},
        {32'h0000_0080, 8'd20, 8'd5},
        {32'h0000_00C3, 8'd16, 8'd12},
        {32'h0000_0300, 8'd0,  8'd4}
    };

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] exp_line(input logic [31:0] addr, input int size);
        logic [127:0] r = '0;
        for (int i = 0; i < 4; i++) begin
            if (i < size / 4) r[i*32 +: 32] = shadow[((addr >> 2) + i) % MEMW];
        end
        return r;
    endfunction

    task automatic issue(input logic rd, input logic wr, input logic [31:0] addr,
                         input int size, input logic [127:0] wd, input int lat);
        @(negedge clk);
        req_valid = 1'b1; req_rd = rd; req_wr = wr; req_addr = addr;
        req_size = 5'(size); req_wdata = wd; req_lat = 8'(lat);
        @(negedge clk);
        req_valid = 1'b0; req_rd = 1'b0; req_wr = 1'b0;
        if (wr) begin
            for (int i = 0; i < 4; i++) begin
                if (i < size / 4) shadow[((addr >> 2) + i) % MEMW] = wd[i*32 +: 32];
            end
        end
    endtask

    task automatic wait_rsp(output int k);
        k = 0;
        while (!rsp_valid && k < 300) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < MEMW; i++) shadow[i] = '0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int k;
        logic [127:0] e;
        logic [127:0] wd;
        for (int i = 0; i < MEMW; i++) shadow[i] = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 req_ready after reset", 128'(req_ready), 128'd1);
        chk("R1 rsp_valid after reset", 128'(rsp_valid), 128'd0);
        chk("R1 rsp_addr after reset", 128'(rsp_addr), 128'd0);
        chk("R1 rsp_data after reset", rsp_data, 128'd0);

        // Vector table: write a line, then read it back with its own latency (R2, R3)
        fill_accept = 1'b1;
        for (int v = 0; v < 8; v++) begin
            logic [31:0] a  = VEC[v][47:16];
            int          sz = int'(VEC[v][15:8]);
            int          lt = int'(VEC[v][7:0]);
            for (int i = 0; i < 4; i++) wd[i*32 +: 32] = 32'hC0DE_0000 + 32'(v << 8) + 32'(i);
            issue(1'b0, 1'b1, a, 16, wd, 0);
            e = exp_line(a, sz);
            issue(1'b1, 1'b0, a, sz, '0, lt);
            wait_rsp(k);
            chk($sformatf("R2 latency vec%0d", v), 128'(k), 128'(lt + 1));
            chk($sformatf("R3 rsp_addr vec%0d", v), 128'(rsp_addr), 128'(a));
            chk($sformatf("R3 rsp_data vec%0d", v), rsp_data, e);
            @(negedge clk);
            chk($sformatf("R8 idle after vec%0d", v), {rsp_valid, rsp_addr, rsp_data[94:0]}, '0);
        end

        // R5: write creates no fill
        issue(1'b0, 1'b1, 32'h0000_0500 & 32'h3FC, 16, {4{32'h1111_2222}}, 0);
        k = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (rsp_valid) k++;
        end
        chk("R5 write gives no fill", 128'(k), 128'd0);

        // R5: partial write keeps upper words; read next cycle sees new data
        issue(1'b0, 1'b1, 32'h0000_0020, 16, {32'hA3, 32'hA2, 32'hA1, 32'hA0}, 0);
        issue(1'b0, 1'b1, 32'h0000_0020, 8, {32'hB3, 32'hB2, 32'hB1, 32'hB0}, 0);
        issue(1'b1, 1'b0, 32'h0000_0020, 16, '0, 0);
        wait_rsp(k);
        chk("R5 partial write", rsp_data, {32'hA3, 32'hA2, 32'hB1, 32'hB0});

        // R4: data captured at acceptance, later write does not change it
        e = exp_line(32'h20, 16);
        issue(1'b1, 1'b0, 32'h0000_0020, 16, '0, 4);
        issue(1'b0, 1'b1, 32'h0000_0020, 16, {4{32'hDEAD_BEEF}}, 0);
        wait_rsp(k);
        chk("R4 captured data", rsp_data, e);
        issue(1'b1, 1'b0, 32'h0000_0020, 16, '0, 0);
        wait_rsp(k);
        chk("R5 new data visible", rsp_data, {4{32'hDEAD_BEEF}});

        // R7: ready young read overtakes a slow older one
        issue(1'b1, 1'b0, 32'h0000_0100, 16, '0, 10);
        issue(1'b1, 1'b0, 32'h0000_0140, 16, '0, 1);
        wait_rsp(k);
        chk("R7 young first", 128'(rsp_addr), 128'h140);
        @(negedge clk);
        wait_rsp(k);
        chk("R7 old second", 128'(rsp_addr), 128'h100);
        @(negedge clk);

        // R10/R6/R7: both ready while accept is low; lowest slot released first
        fill_accept = 1'b0;
        issue(1'b1, 1'b0, 32'h0000_0180, 16, '0, 3);
        issue(1'b1, 1'b0, 32'h0000_01C0, 16, '0, 0);
        k = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (rsp_valid) k++;
        end
        chk("R6 no fill without accept", 128'(k), 128'd0);
        fill_accept = 1'b1;
        @(negedge clk);
        chk("R10 slot0 ready after wait", 128'({rsp_valid, rsp_addr}), 128'({1'b1, 32'h180}));
        @(negedge clk);
        chk("R7 slot1 next cycle", 128'({rsp_valid, rsp_addr}), 128'({1'b1, 32'h1C0}));
        @(negedge clk);
        chk("R8 idle after drain", {rsp_valid, rsp_addr, rsp_data[94:0]}, '0);

        // R9: full table, extra read refused
        fill_accept = 1'b0;
        for (int s = 0; s < 4; s++) issue(1'b1, 1'b0, 32'(32'h400 + s * 16), 16, '0, 2);
        chk("R9 ready low when full", 128'(req_ready), 128'd0);
        issue(1'b1, 1'b0, 32'h0000_0480, 16, '0, 0);
        fill_accept = 1'b1;
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            chk($sformatf("R9 drain slot%0d", s), 128'({rsp_valid, rsp_addr}),
                128'({1'b1, 32'(32'h400 + s * 16)}));
            if (s == 0) chk("R9 ready after free", 128'(req_ready), 128'd1);
        end
        k = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (rsp_valid) k++;
        end
        chk("R9 refused read never filled", 128'(k), 128'd0);

        // R1: reset drops a pending read and clears memory
        issue(1'b1, 1'b0, 32'h0000_0010, 16, '0, 20);
        do_reset();
        k = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (rsp_valid) k++;
        end
        chk("R1 pending read dropped", 128'(k), 128'd0);
        issue(1'b1, 1'b0, 32'h0000_0010, 16, '0, 0);
        wait_rsp(k);
        chk("R1 memory cleared", {rsp_valid, rsp_data[126:0]}, {1'b1, 127'd0});

        summary();
        $finish;
    end
endmodule